// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Width Detection

This block is the serial side of an 8-bit PCM channel. Each transmit frame sends one byte, MSB first, on a serial line with its own output enable. Each receive frame collects one byte from a serial input and presents it in parallel with a one-cycle strobe. Bit clocks and frame syncs come from outside and are sampled by a faster system clock. All edge detection works on the synchronized copies. The parallel transmit byte is taken in when a frame starts and is sent in the frame after that, so the sender always gets one full frame to prepare its next byte.

Framing has two timings. In short timing the sync is one bit period wide and announces the frame one bit ahead. In long timing the sync is several periods wide and frames the data directly. The port measures the width of the transmit sync and chooses the timing from it. The choice applies to both directions from the next frame onward. After reset the port uses short timing until a wide sync is seen.

Top module: `pcm_port`

## Requirements
- R1: After reset `tx_oe`, `tx_dout`, `rx_valid` and `rx_byte` are all 0, and the framing is short. The held transmit byte is 0x00, so the first frame after reset sends 0x00.
- R2: The framing is chosen when the transmit sync falls, based on how many bit-clock falling edges found it high. Three or more selects long framing, exactly one selects short framing, and two leaves the framing unchanged. A frame uses the framing that was in force when it started.
- R3: In short framing, a transmit sync that is high at a bit-clock falling edge starts a frame. The next rising edge raises `tx_oe` and drives the first bit. Each of the following seven rising edges drives the next bit. The falling edge after the eighth bit lowers `tx_oe`.
- R4: In long framing, `tx_oe` rises and the first bit is driven at the later of two events: the transmit sync rising, or the bit clock rising. If the sync rises while the bit clock is low, the output stays disabled until the next rising edge.
- R5: In long framing, `tx_oe` falls at the later of two events: the bit-clock falling edge after the eighth bit, or the transmit sync going low.
- R6: The byte on `tx_byte` is captured when a transmit frame starts and is sent in the following frame.
- R7: Bits are sent MSB first. While `tx_oe` is high, `tx_dout` changes only after a bit-clock rising edge.
- R8: In short framing, a receive sync that is high at a bit-clock falling edge arms the receiver. The next eight falling edges capture the bits, MSB first.
- R9: In long framing, a rising receive sync arms the receiver. The next eight falling edges capture the bits, MSB first.
- R10: After the eighth captured bit, `rx_byte` holds the byte and `rx_valid` is high for exactly one system clock. This happens once per receive frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples all serial signals |
| rst_n | input | 1 | Active-low reset |
| bclk_tx | input | 1 | Transmit bit clock |
| bclk_rx | input | 1 | Receive bit clock |
| fs_tx | input | 1 | Transmit frame sync; its width also selects the framing |
| fs_rx | input | 1 | Receive frame sync |
| rx_din | input | 1 | Serial receive data |
| tx_byte | input | 8 | Byte to send in the next transmit frame |
| tx_dout | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Enable for the external tri-state driver of `tx_dout` |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when `rx_byte` is updated |

## Verification
The hardest case to reach is a frame where the framing changes partway through. A wide sync that arrives while the port is still in short framing is sent with short timing, so its first bit lands one period late. The switch to long framing only affects the frames after it. The stimulus table therefore includes a training frame each time the framing changes, and checks that the output is still disabled during the first data period of that frame. A long frame also holds its sync past the eighth bit, to show that the disable waits for the sync to fall. Every long sync rises during a bit-clock low phase, to show that the enable waits for the next rising edge.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
   typedef enum logic [1:0] {
      TX_IDLE,
      TX_WAIT,
      TX_SHIFT,
      TX_TAIL
   } tx_state_e;

   typedef enum logic {
      RX_IDLE,
      RX_CAP
   } rx_state_e;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pcm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= '0;
      else        pipe[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/pcm_edge.sv
module pcm_edge #(
   parameter int WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sig,
   output logic [WIDTH-1:0] rise,
   output logic [WIDTH-1:0] fall
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
   assign fall = ~sig & prev_q;
endmodule

// File: rtl/pcm_mode_det.sv
module pcm_mode_det #(
   parameter int LONG_MIN = 3,
   localparam int CNT_W   = $clog2(LONG_MIN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bfall,
   input  logic fs,
   input  logic fs_rise,
   input  logic fs_fall,
   output logic long_mode
);
   generate
      if (LONG_MIN < 2) begin : g_bad_min
         $error("pcm_mode_det: LONG_MIN must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] width_q;
   logic [CNT_W-1:0] base;
   logic             bump;

   always_comb begin
      base = fs_rise ? '0 : width_q;
      bump = bfall && fs && (base < CNT_W'(LONG_MIN));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width_q   <= '0;
         long_mode <= 1'b0;
      end else begin
         width_q <= base + CNT_W'(bump);
         if (fs_fall) begin
            if (width_q >= CNT_W'(LONG_MIN))  long_mode <= 1'b1;
            else if (width_q == CNT_W'(1))    long_mode <= 1'b0;
         end
      end
   end

   // R2: the framing only changes in the cycle after the sync falls
   a_r2_mode_on_sync_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(long_mode) |-> $past(fs_fall));
endmodule

// File: rtl/pcm_tx.sv
module pcm_tx
   import pcm_pkg::*;
#(
   parameter int WORD_W = 8,
   localparam int CNT_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_mode,
   input  logic              blevel,
   input  logic              brise,
   input  logic              bfall,
   input  logic              fs,
   input  logic              fs_rise,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              dout,
   output logic              oe
);
   tx_state_e         state_q;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] hold_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              flong_q;
   logic              start;

   assign start = (state_q == TX_IDLE) &&
                  (long_mode ? fs_rise : (bfall && fs));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         sh_q    <= '0;
         hold_q  <= '0;
         cnt_q   <= '0;
         flong_q <= 1'b0;
         oe      <= 1'b0;
      end else begin
         case (state_q)
            TX_IDLE: if (start) begin
               sh_q    <= hold_q;
               hold_q  <= tx_byte;
               flong_q <= long_mode;
               if (long_mode && blevel) begin
                  state_q <= TX_SHIFT;
                  oe      <= 1'b1;
                  cnt_q   <= CNT_W'(1);
               end else begin
                  state_q <= TX_WAIT;
               end
            end
            TX_WAIT: if (brise) begin
               state_q <= TX_SHIFT;
               oe      <= 1'b1;
               cnt_q   <= CNT_W'(1);
            end
            TX_SHIFT: begin
               if (brise && cnt_q < CNT_W'(WORD_W)) begin
                  sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
                  cnt_q <= cnt_q + CNT_W'(1);
               end else if (bfall && cnt_q == CNT_W'(WORD_W)) begin
                  if (flong_q && fs) begin
                     state_q <= TX_TAIL;
                  end else begin
                     state_q <= TX_IDLE;
                     oe      <= 1'b0;
                  end
               end
            end
            TX_TAIL: if (!fs) begin
               state_q <= TX_IDLE;
               oe      <= 1'b0;
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign dout = oe & sh_q[WORD_W-1];

   // R3, R5: the enable drops only on a bit-clock falling edge or a low sync
   a_r5_oe_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe) |-> $past(bfall || !fs));
   // R7: the data bit moves only after a bit-clock rising edge
   a_r7_bit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (oe && $past(oe) && !$stable(sh_q[WORD_W-1])) |-> $past(brise));
   // R4: the enable rises only on a rising bit clock or rising sync
   a_r4_oe_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(brise || fs_rise));
endmodule

// File: rtl/pcm_rx.sv
module pcm_rx
   import pcm_pkg::*;
#(
   parameter int WORD_W = 8,
   localparam int CNT_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              long_mode,
   input  logic              bfall,
   input  logic              fs,
   input  logic              fs_rise,
   input  logic              din,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);
   rx_state_e         state_q;
   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              arm;

   assign arm = long_mode ? fs_rise : (bfall && fs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_IDLE;
         sh_q     <= '0;
         cnt_q    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         case (state_q)
            RX_IDLE: if (arm) begin
               state_q <= RX_CAP;
               cnt_q   <= '0;
            end
            RX_CAP: if (bfall) begin
               sh_q  <= {sh_q[WORD_W-2:0], din};
               cnt_q <= cnt_q + CNT_W'(1);
               if (cnt_q == CNT_W'(WORD_W - 1)) begin
                  rx_byte  <= {sh_q[WORD_W-2:0], din};
                  rx_valid <= 1'b1;
                  state_q  <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   // R10: the strobe lasts a single cycle
   a_r10_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   // R8, R9: a byte completes only on a bit-clock falling edge
   a_r8_valid_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bfall));
endmodule

// File: rtl/pcm_port.sv
module pcm_port #(
   parameter int WORD_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int LONG_MIN    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_tx,
   input  logic              bclk_rx,
   input  logic              fs_tx,
   input  logic              fs_rx,
   input  logic              rx_din,
   input  logic [WORD_W-1:0] tx_byte,
   output logic              tx_dout,
   output logic              tx_oe,
   output logic [WORD_W-1:0] rx_byte,
   output logic              rx_valid
);
   localparam int I_BTX = 0;
   localparam int I_BRX = 1;
   localparam int I_FTX = 2;
   localparam int I_FRX = 3;
   localparam int N_EDGE = 4;
   localparam int N_SYNC = N_EDGE + 1;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("pcm_port: WORD_W must be at least 2");
      end
   endgenerate

   logic [N_SYNC-1:0] raw, synced;
   logic [N_EDGE-1:0] rises, falls;
   logic              long_mode;

   assign raw = {rx_din, fs_rx, fs_tx, bclk_rx, bclk_tx};

   pcm_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (synced)
   );

   pcm_edge #(.WIDTH(N_EDGE)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   (synced[N_EDGE-1:0]),
      .rise  (rises),
      .fall  (falls)
   );

   pcm_mode_det #(.LONG_MIN(LONG_MIN)) u_mode (
      .clk       (clk),
      .rst_n     (rst_n),
      .bfall     (falls[I_BTX]),
      .fs        (synced[I_FTX]),
      .fs_rise   (rises[I_FTX]),
      .fs_fall   (falls[I_FTX]),
      .long_mode (long_mode)
   );

   pcm_tx #(.WORD_W(WORD_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .long_mode (long_mode),
      .blevel    (synced[I_BTX]),
      .brise     (rises[I_BTX]),
      .bfall     (falls[I_BTX]),
      .fs        (synced[I_FTX]),
      .fs_rise   (rises[I_FTX]),
      .tx_byte   (tx_byte),
      .dout      (tx_dout),
      .oe        (tx_oe)
   );

   pcm_rx #(.WORD_W(WORD_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .long_mode (long_mode),
      .bfall     (falls[I_BRX]),
      .fs        (synced[I_FRX]),
      .fs_rise   (rises[I_FRX]),
      .din       (synced[N_SYNC-1]),
      .rx_byte   (rx_byte),
      .rx_valid  (rx_valid)
   );

   // R1: the enable is low in the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> !tx_oe && !rx_valid);
   // R3: the serial data is 0 whenever the driver is disabled
   a_r3_dout_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_oe |-> !tx_dout);
endmodule

// File: tb/tb_pcm_port.sv
module tb_pcm_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bclk = 1'b0;
   logic       fs = 1'b0;
   logic       din = 1'b0;
   logic [7:0] tx_byte = 8'h00;
   logic       tx_dout, tx_oe, rx_valid;
   logic [7:0] rx_byte;

   int n_tests = 0;
   int n_fail  = 0;
   int vcnt    = 0;
   logic [7:0] last_rx = 8'h00;

   always #5 clk = ~clk;

   pcm_port dut (
      .clk(clk), .rst_n(rst_n),
      .bclk_tx(bclk), .bclk_rx(bclk),
      .fs_tx(fs), .fs_rx(fs),
      .rx_din(din), .tx_byte(tx_byte),
      .tx_dout(tx_dout), .tx_oe(tx_oe),
      .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   always @(negedge clk) if (rx_valid) begin
      vcnt    = vcnt + 1;
      last_rx = rx_byte;
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // fields: long, train, hold, tx byte, rx byte, expected tx byte
   localparam int NV = 8;
   localparam logic [26:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'h00},
      {1'b0, 1'b0, 1'b0, 8'h5A, 8'hC3, 8'hA5},
      {1'b1, 1'b1, 1'b0, 8'h11, 8'h00, 8'h5A},
      {1'b1, 1'b0, 1'b0, 8'h96, 8'h81, 8'h11},
      {1'b1, 1'b0, 1'b1, 8'h0F, 8'h7E, 8'h96},
      {1'b0, 1'b1, 1'b0, 8'hF0, 8'h00, 8'h0F},
      {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'hF0},
      {1'b0, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFF}
   };

   // One frame of 12 bit periods, 16 system clocks each; data in periods 1..8.
   task automatic run_frame(input logic lng, input logic train, input logic hold,
                            input logic [7:0] txv, input logic [7:0] rxv,
                            input logic [7:0] exp_tx);
      int fs_end;
      fs_end = hold ? 9 : 3;
      @(negedge clk);
      tx_byte = txv;
      vcnt    = 0;
      for (int p = 0; p < 12; p++) begin
         @(negedge clk);
         bclk = 1'b1;
         if (!lng) fs = (p == 0);
         else if (p == fs_end + 1) fs = 1'b0;
         din = (p >= 1 && p <= 8) ? rxv[8-p] : 1'b0;
         repeat (7) @(negedge clk);
         if (!train && p >= 1 && p <= 8) begin
            chk(tx_oe == 1'b1, lng ? "R4 oe during bit" : "R3 oe during bit", tx_oe, 1);
            chk(tx_dout == exp_tx[8-p], "R7 R6 tx bit", tx_dout, exp_tx[8-p]);
         end
         if (train && lng && p == 1)
            chk(tx_oe == 1'b0, "R2 wide sync still short-timed", tx_oe, 0);
         @(negedge clk);
         bclk = 1'b0;
         repeat (3) @(negedge clk);
         if (lng && p == 0) fs = 1'b1;
         repeat (4) @(negedge clk);
         if (!train) begin
            if (p == 0)
               chk(tx_oe == 1'b0, lng ? "R4 enable waits for rise" : "R3 idle before frame", tx_oe, 0);
            if (p == 8)
               chk(tx_oe == hold, hold ? "R5 oe held by sync" : "R3 R5 oe off after bit 8", tx_oe, hold);
            if (hold && p == 9)
               chk(tx_oe == 1'b1, "R5 oe held by sync", tx_oe, 1);
            if (hold && p == 10)
               chk(tx_oe == 1'b0, "R5 oe off after sync low", tx_oe, 0);
         end
      end
      if (!train) begin
         chk(vcnt == 1, "R10 one strobe per frame", vcnt, 1);
         chk(last_rx == rxv, lng ? "R9 long rx byte" : "R8 short rx byte", last_rx, rxv);
      end
   endtask

   initial begin
      fork
         begin
            repeat (150000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
         end
      join_none

      repeat (4) @(negedge clk);
      chk(tx_oe == 0 && tx_dout == 0, "R1 tx idle in reset", tx_oe, 0);
      chk(rx_valid == 0 && rx_byte == 0, "R1 rx idle in reset", rx_byte, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      for (int i = 0; i < NV; i++)
         run_frame(VEC[i][26], VEC[i][25], VEC[i][24],
                   VEC[i][23:16], VEC[i][15:8], VEC[i][7:0]);

      // Directed: reset in long framing returns to short framing and a zero hold byte (R1)
      run_frame(1'b1, 1'b1, 1'b0, 8'h22, 8'h00, 8'h00);
      run_frame(1'b1, 1'b0, 1'b0, 8'h33, 8'h44, 8'h22);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(tx_oe == 0 && rx_byte == 0, "R1 reset clears outputs", rx_byte, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      run_frame(1'b0, 1'b0, 1'b0, 8'hC7, 8'h5B, 8'h00);
      run_frame(1'b1, 1'b1, 1'b0, 8'h18, 8'h00, 8'hC7);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule